// File: doc/BRIEF.md
# Multi-channel interval timer

This block is a register-mapped timer with a set of independent 32-bit down counters. Software gives each channel a reload value and turns it on. The counter then steps down once per clock. When it passes through zero it raises a sticky event flag, fetches its reload value again and keeps running. It never stops after a single period, so the block always runs periodically. Each channel drives its own interrupt line, which is active while that channel's flag and interrupt enable are both set.

A global halt bit freezes every counter at once; the block leaves reset with halt set. A channel can be linked to its lower-numbered neighbour. A linked channel steps only in the cycles in which the neighbour wraps, so two channels together form a 64-bit count. Software can read a free-running channel loaded with all ones and invert the value to obtain an up-count. The register bus is a single-cycle interface: writes take effect at the clock edge, and read data is combinational from the address.

Top module: `irq_tick_timer`

## Requirements
- R1: After reset the global control register reads 0x2 (halt set), every channel register reads 0, and all interrupt lines are low.
- R2: Global control is at address 0x000, with the halt bit at bit 1. Channel n occupies 0x100 + 0x10*n. Its reload value is at +0x0, the live count at +0x4 (read-only), the control register at +0x8 and the flag register at +0xC. Control bit 0 is run, bit 1 is interrupt enable and bit 2 is link. Flag bit 0 is the event flag. All of these registers read back what they hold.
- R3: A write that changes run from 0 to 1 loads the count from the reload register at that edge. While run is 0, the count follows the reload value.
- R4: A running, unhalted and unlinked channel decrements once per clock. In the cycle its count is 0 it reloads and sets its flag, so the period is reload+1 cycles.
- R5: Writing the reload register of a running channel does not change the current count. The new value is used at the next wrap.
- R6: Writing 1 to flag bit 0 clears the flag, and writing 0 leaves it unchanged. A wrap in the same cycle as a clear leaves the flag set.
- R7: The interrupt line of a channel is high exactly while its flag and its interrupt enable are both 1.
- R8: While halt is 1, no channel count changes, except for the load caused by a run write.
- R9: A linked channel n>0 steps (decrements or wraps) only in cycles in which channel n-1 wraps. The link bit of channel 0 has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| irq | output | NCH | One interrupt line per channel |

## Verification
The counting function is exercised with a short reload of 5, with a reload of 1 (the smallest period), and with a reload rewritten while the channel runs. The last case separates a restart-on-write design from one that defers the value to the next wrap. A halt applied in the middle of a period, followed by its release, shows that counting freezes and resumes with no step lost or added. A chained pair with different reloads on the two channels shows whether the upper channel steps on every clock or only on neighbour wraps. The masked-interrupt case and the write-zero-to-flag case show that the interrupt output and the flag register respond only to the fields they are meant to.

// File: rtl/irq_tick_pkg.sv
package irq_tick_pkg;
  localparam int DW        = 32;
  localparam int AW        = 12;
  localparam int CH_BASE   = 'h100;
  localparam int CH_STRIDE = 'h10;
  localparam int MOD_ADDR  = 'h000;
  localparam int OFF_LOAD  = 'h0;
  localparam int OFF_CNT   = 'h4;
  localparam int OFF_CTL   = 'h8;
  localparam int OFF_FLG   = 'hC;
  localparam int HALT_BIT  = 1;

  typedef struct packed {
    logic link;
    logic ie;
    logic run;
  } ctl_t;

  function automatic logic [AW-1:0] ch_addr(input int n, input int off);
    return AW'(CH_BASE + CH_STRIDE * n + off);
  endfunction
endpackage

// File: rtl/irq_tick_chan.sv
module irq_tick_chan
  import irq_tick_pkg::*;
#(
  parameter int IDX = 0
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          halt,
  input  logic          ld_we,
  input  logic [DW-1:0] ld_wdata,
  input  logic          ctl_we,
  input  ctl_t          ctl_wdata,
  input  logic          flg_clr,
  input  logic          chain_in,
  output logic [DW-1:0] load_q,
  output logic [DW-1:0] cnt_q,
  output ctl_t          ctl_q,
  output logic          flag_q,
  output logic          expire,
  output logic          irq
);
  logic [DW-1:0] load_d, cnt_d;
  ctl_t          ctl_d;
  logic          flag_d, tick, run_rise;

  // step enable: every clock, or only on neighbour wraps when linked
  always_comb begin
    tick = !halt;
    if (IDX != 0 && ctl_q.link) tick = !halt && chain_in;
  end

  assign run_rise = ctl_we && ctl_wdata.run && !ctl_q.run;
  assign expire   = ctl_q.run && tick && (cnt_q == '0);

  always_comb begin
    load_d = ld_we  ? ld_wdata  : load_q;
    ctl_d  = ctl_we ? ctl_wdata : ctl_q;
    flag_d = expire || (flag_q && !flg_clr);
    cnt_d  = cnt_q;
    if (!ctl_d.run || run_rise) begin
      cnt_d = load_q;
    end else if (tick) begin
      cnt_d = (cnt_q == '0) ? load_q : cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      load_q <= '0;
      cnt_q  <= '0;
      ctl_q  <= '0;
      flag_q <= 1'b0;
    end else begin
      load_q <= load_d;
      cnt_q  <= cnt_d;
      ctl_q  <= ctl_d;
      flag_q <= flag_d;
    end
  end

  assign irq = flag_q && ctl_q.ie;
endmodule

// File: rtl/irq_tick_regs.sv
module irq_tick_regs
  import irq_tick_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_sel,
  input  logic                    bus_wr,
  input  logic [AW-1:0]           bus_addr,
  input  logic                    halt_wbit,
  output logic [NCH-1:0]          ld_we,
  output logic [NCH-1:0]          ctl_we,
  output logic [NCH-1:0]          flg_we,
  output logic                    halt,
  input  logic [NCH-1:0][DW-1:0]  load_w,
  input  logic [NCH-1:0][DW-1:0]  cnt_w,
  input  ctl_t [NCH-1:0]          ctl_w,
  input  logic [NCH-1:0]          flag_w,
  output logic [DW-1:0]           bus_rdata
);
  logic wr_cyc, mod_we, halt_d;

  assign wr_cyc = bus_sel && bus_wr;
  assign mod_we = wr_cyc && (bus_addr == AW'(MOD_ADDR));

  for (genvar n = 0; n < NCH; n++) begin : g_dec
    assign ld_we[n]  = wr_cyc && (bus_addr == ch_addr(n, OFF_LOAD));
    assign ctl_we[n] = wr_cyc && (bus_addr == ch_addr(n, OFF_CTL));
    assign flg_we[n] = wr_cyc && (bus_addr == ch_addr(n, OFF_FLG));
  end

  assign halt_d = mod_we ? halt_wbit : halt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) halt <= 1'b1;
    else        halt <= halt_d;
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      if (bus_addr == AW'(MOD_ADDR)) bus_rdata[HALT_BIT] = halt;
      for (int n = 0; n < NCH; n++) begin
        if (bus_addr == ch_addr(n, OFF_LOAD)) bus_rdata = load_w[n];
        if (bus_addr == ch_addr(n, OFF_CNT))  bus_rdata = cnt_w[n];
        if (bus_addr == ch_addr(n, OFF_CTL))  bus_rdata = DW'(ctl_w[n]);
        if (bus_addr == ch_addr(n, OFF_FLG))  bus_rdata = DW'(flag_w[n]);
      end
    end
  end
endmodule

// File: rtl/irq_tick_timer.sv
module irq_tick_timer
  import irq_tick_pkg::*;
#(
  parameter int NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [11:0]    bus_addr,
  input  logic [31:0]    bus_wdata,
  output logic [31:0]    bus_rdata,
  output logic [NCH-1:0] irq
);
  logic [1:0]            rst_sync;
  logic                  rst_sync_n;
  logic                  halt_w;
  logic [NCH-1:0]        ld_we, ctl_we, flg_we, flag_w, expire_w, chain_w;
  logic [NCH-1:0][DW-1:0] load_w, cnt_w;
  ctl_t [NCH-1:0]        ctl_w;

  // asynchronous assert, synchronous release
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_sync_n = rst_sync[1];

  irq_tick_regs #(.NCH(NCH)) regs_i (
    .clk       (clk),
    .rst_n     (rst_sync_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .halt_wbit (bus_wdata[HALT_BIT]),
    .ld_we     (ld_we),
    .ctl_we    (ctl_we),
    .flg_we    (flg_we),
    .halt      (halt_w),
    .load_w    (load_w),
    .cnt_w     (cnt_w),
    .ctl_w     (ctl_w),
    .flag_w    (flag_w),
    .bus_rdata (bus_rdata)
  );

  for (genvar n = 0; n < NCH; n++) begin : g_ch
    if (n == 0) begin : g_first
      assign chain_w[n] = 1'b0;
    end else begin : g_link
      assign chain_w[n] = expire_w[n-1];
    end

    irq_tick_chan #(.IDX(n)) chan_i (
      .clk       (clk),
      .rst_n     (rst_sync_n),
      .halt      (halt_w),
      .ld_we     (ld_we[n]),
      .ld_wdata  (bus_wdata),
      .ctl_we    (ctl_we[n]),
      .ctl_wdata (ctl_t'(bus_wdata[2:0])),
      .flg_clr   (flg_we[n] && bus_wdata[0]),
      .chain_in  (chain_w[n]),
      .load_q    (load_w[n]),
      .cnt_q     (cnt_w[n]),
      .ctl_q     (ctl_w[n]),
      .flag_q    (flag_w[n]),
      .expire    (expire_w[n]),
      .irq       (irq[n])
    );
  end
endmodule

// File: rtl/irq_tick_chk.sv
module irq_tick_chk
  import irq_tick_pkg::*;
#(
  parameter int NCH = 4
) (
  input logic                   clk,
  input logic                   rst_sync_n,
  input logic                   bus_sel,
  input logic                   bus_wr,
  input logic [AW-1:0]          bus_addr,
  input logic                   wdata0,
  input logic                   halt_w,
  input ctl_t [NCH-1:0]         ctl_w,
  input logic [NCH-1:0]         flag_w,
  input logic [NCH-1:0]         expire_w,
  input logic [NCH-1:0][DW-1:0] cnt_w,
  input logic [NCH-1:0]         irq
);
  for (genvar n = 0; n < NCH; n++) begin : g_p
    logic ctl_wr, flg_clr;
    assign ctl_wr  = bus_sel && bus_wr && (bus_addr == ch_addr(n, OFF_CTL));
    assign flg_clr = bus_sel && bus_wr && wdata0 && (bus_addr == ch_addr(n, OFF_FLG));

    // R8
    halt_freeze_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (halt_w && ctl_w[n].run && !ctl_wr) |=> $stable(cnt_w[n]));

    // R6
    flag_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      (flag_w[n] && !flg_clr) |=> flag_w[n]);

    // R4
    expire_flag_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      expire_w[n] |=> flag_w[n]);

    // R7
    irq_mask_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
      !ctl_w[n].ie |-> !irq[n]);

    if (n > 0) begin : g_chain
      // R9
      chain_hold_chk: assert property (@(posedge clk) disable iff (!rst_sync_n)
        (ctl_w[n].link && ctl_w[n].run && !expire_w[n-1] && !ctl_wr)
          |=> $stable(cnt_w[n]));
    end
  end
endmodule

bind irq_tick_timer irq_tick_chk #(.NCH(NCH)) chk_i (
  .clk        (clk),
  .rst_sync_n (rst_sync_n),
  .bus_sel    (bus_sel),
  .bus_wr     (bus_wr),
  .bus_addr   (bus_addr),
  .wdata0     (bus_wdata[0]),
  .halt_w     (halt_w),
  .ctl_w      (ctl_w),
  .flag_w     (flag_w),
  .expire_w   (expire_w),
  .cnt_w      (cnt_w),
  .irq        (irq)
);

// File: tb/irq_tick_timer_tb.sv
`timescale 1ns/1ps
module irq_tick_timer_tb_top;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_sel, bus_wr;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata, bus_rdata;
  logic [3:0]  irq;

  always #2 clk = ~clk;

  irq_tick_timer #(.NCH(4)) dut_i (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  logic [31:0] exp_q[$];
  bit          kind_q[$];
  string       tag_q[$];
  int          checks = 0, failures = 0;
  bit          done = 1'b0;
  logic [31:0] m_exp, m_act;
  bit          m_kind;
  string       m_tag;

  function automatic logic [11:0] ca(input int n, input int off);
    return 12'(32'h100 + 16 * n + off);
  endfunction

  // monitor: compare one queued expectation per cycle, after the drive
  always @(negedge clk) begin
    #1;
    if (exp_q.size() != 0) begin
      m_exp  = exp_q.pop_front();
      m_kind = kind_q.pop_front();
      m_tag  = tag_q.pop_front();
      m_act  = m_kind ? 32'(irq) : bus_rdata;
      checks++;
      if (m_act !== m_exp) begin
        failures++;
        $display("FAIL %s actual=0x%08h expected=0x%08h", m_tag, m_act, m_exp);
      end
    end
  end

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    exp_q.push_back(e); kind_q.push_back(1'b0); tag_q.push_back(t);
  endtask

  task automatic irqchk(input logic [31:0] e, input string t);
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
    exp_q.push_back(e); kind_q.push_back(1'b1); tag_q.push_back(t);
  endtask

  initial begin
    rst_n = 1'b0; bus_sel = 1'b0; bus_wr = 1'b0; bus_addr = '0; bus_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    rd(12'h000, 32'h2, "R1 halt set after reset");
    rd(ca(0, 4), 0, "R1 ch0 count zero");
    rd(ca(3, 8), 0, "R1 ch3 control zero");
    irqchk(0, "R1 irq low");
    wr(12'h000, 0);
    rd(12'h000, 0, "R2 halt cleared");

    // ch1, reload 5, run + interrupt enable
    wr(ca(1, 0), 5);
    wr(ca(1, 8), 3);
    rd(ca(1, 4), 5, "R3 count loaded on run");
    rd(ca(1, 4), 4, "R4 decrement");
    wr(ca(1, 0), 9);
    rd(ca(1, 4), 2, "R5 reload write keeps count");
    rd(ca(1, 12), 0, "R4 flag clear before wrap");
    idle(1);
    rd(ca(1, 12), 1, "R4 flag after reload+1 cycles");
    rd(ca(1, 4), 8, "R5 new reload used at wrap");
    irqchk(32'h2, "R7 irq with flag and enable");
    wr(ca(1, 12), 0);
    rd(ca(1, 12), 1, "R6 write zero keeps flag");
    wr(ca(1, 12), 1);
    irqchk(0, "R7 irq drops after clear");
    rd(ca(1, 12), 0, "R6 write one clears flag");
    wr(ca(1, 8), 0);
    rd(ca(1, 4), 9, "R3 stopped count follows reload");

    // halt in mid-period
    wr(ca(1, 8), 3);
    wr(12'h000, 2);
    rd(ca(1, 4), 8, "R8 last step before halt");
    rd(ca(1, 4), 8, "R8 frozen while halted");
    wr(12'h000, 0);
    rd(ca(1, 4), 8, "R8 no step at release edge");
    rd(ca(1, 4), 7, "R8 resumes after release");
    wr(ca(1, 8), 0);

    // smallest period, interrupt masked
    wr(ca(2, 0), 1);
    wr(ca(2, 8), 1);
    rd(ca(2, 8), 1, "R2 control readback");
    idle(1);
    rd(ca(2, 12), 1, "R4 flag after 2 cycles with reload 1");
    irqchk(0, "R7 masked flag keeps irq low");
    wr(ca(2, 8), 0);

    // chain ch1 to ch0
    wr(ca(1, 0), 1);
    wr(ca(1, 8), 5);
    wr(ca(0, 0), 2);
    wr(ca(0, 8), 1);
    rd(ca(1, 4), 1, "R9 linked holds without neighbour wrap");
    idle(2);
    rd(ca(1, 4), 0, "R9 linked steps on neighbour wrap");
    rd(ca(0, 4), 1, "R4 ch0 runs every clock");
    rd(ca(1, 12), 0, "R9 linked no flag yet");
    rd(ca(1, 4), 1, "R9 linked wraps on second neighbour wrap");
    rd(ca(1, 12), 1, "R9 linked flag set");
    idle(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule